// File: doc/BRIEF.md
# Shift and Rotate Unit with Condition Flags

This block is a purely combinational shift and rotate stage for a processor execute path. It takes a word operand and moves it right arithmetically, left logically, right logically, right circularly, or right by one position through the carry flag. The amount comes either from a small immediate field or from the low byte of a register value. Beside the shifted word it produces negative, zero and carry flags, each paired with a strobe that tells the flag register whether to load.

The amount may come from a register, so it can reach 255. Each operation therefore defines its result and carry for amounts at, above and well past the word width. A zero amount never touches the carry. When flag update is disabled the word is still produced, but no strobe is raised.

Top module: `shifter_unit`

## Requirements
- R1: With op code 0 (arithmetic right) and an amount of 1 to 31, the result is the operand shifted right with every vacated high bit equal to operand bit 31, and the carry is operand bit (amount-1).
- R2: With op code 1 (logical left) and an amount of 1 to 31, the result is the operand shifted left with zeros in the vacated low bits, and the carry is operand bit (32-amount).
- R3: With op code 2 (logical right) and an amount of 1 to 31, the result is the operand shifted right with zeros in the vacated high bits, and the carry is operand bit (amount-1).
- R4: With op code 3 (rotate right) and an amount of 1 to 31, bits leaving the low end re-enter at the high end, and the carry equals result bit 31.
- R5: With op code 4 (rotate through carry) the result is {carry_i, operand[31:1]} whatever the amount inputs hold, and the carry becomes operand bit 0.
- R6: When amt_reg_sel_i is 1 the amount is amt_reg_i[7:0] and bits 31:8 have no effect; when it is 0 the amount is the 6-bit amt_imm_i.
- R7: neg_o is result bit 31 and zero_o is 1 exactly when the result is all zeros; with flag_en_i high both neg_upd_o and zero_upd_o are 1.
- R8: For op codes 0 to 3 with an amount of 0, the result equals the operand, carry_upd_o is 0 and carry_o equals carry_i.
- R9: A logical shift by exactly 32 gives zero with carry equal to operand bit 0 (left) or bit 31 (right); amounts above 32 give zero with carry 0.
- R10: An arithmetic right shift by 32 or more gives every bit equal to operand bit 31, and the carry equals operand bit 31.
- R11: Rotate right uses the amount modulo 32; a nonzero multiple of 32 returns the operand unchanged and sets the carry to operand bit 31.
- R12: With flag_en_i low, neg_upd_o, zero_upd_o and carry_upd_o are all 0, carry_o equals carry_i, and the result is still produced.
- R13: Op codes 5 to 7 pass the operand through unchanged with carry_upd_o at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Operand to shift |
| op_i | input | 3 | Operation code (0 asr, 1 lsl, 2 lsr, 3 ror, 4 rotate through carry) |
| amt_reg_sel_i | input | 1 | 1 selects the register amount, 0 the immediate |
| amt_imm_i | input | 6 | Immediate shift amount |
| amt_reg_i | input | 32 | Register value whose low byte is the amount |
| carry_i | input | 1 | Current carry flag |
| flag_en_i | input | 1 | Flag update enable |
| result_o | output | 32 | Shifted or rotated word |
| neg_o | output | 1 | Negative flag value |
| neg_upd_o | output | 1 | Negative flag load strobe |
| zero_o | output | 1 | Zero flag value |
| zero_upd_o | output | 1 | Zero flag load strobe |
| carry_o | output | 1 | Carry flag value |
| carry_upd_o | output | 1 | Carry flag load strobe |

## Verification
The unit has no register, so the result and every flag and strobe are due in the same cycle the inputs change, after the combinational paths settle. The bench drives each stimulus just after a rising edge and samples all outputs at the following falling edge, half a period later. This leaves the paths time to settle and keeps sampling away from any edge. The vector table covers each operation at ordinary amounts, at zero, at exactly the word width and well past it, and the register byte select. Directed tests then cover the disabled-flag case and the idle state at start.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [2:0] {
    OP_ASR = 3'd0,
    OP_LSL = 3'd1,
    OP_LSR = 3'd2,
    OP_ROR = 3'd3,
    OP_RRC = 3'd4
  } shf_op_e;

  localparam int unsigned AMT_W = 8;
endpackage

// File: rtl/shf_amt.sv
module shf_amt #(
  parameter int unsigned W = 32
) (
  input  logic                  reg_sel_i,
  input  logic [$clog2(W):0]    imm_i,
  input  logic [W-1:0]          reg_i,
  output logic [shf_pkg::AMT_W-1:0] amt_o,
  output logic                  is_zero_o,
  output logic                  is_word_o,
  output logic                  over_word_o,
  output logic [$clog2(W)-1:0]  low_o
);
  localparam int unsigned LG = $clog2(W);
  localparam int unsigned AW = shf_pkg::AMT_W;

  logic unused_reg_hi;
  assign unused_reg_hi = ^reg_i[W-1:AW];

  always_comb begin
    if (reg_sel_i) amt_o = reg_i[AW-1:0];
    else           amt_o = {{(AW-LG-1){1'b0}}, imm_i};
  end

  assign is_zero_o   = (amt_o == '0);
  assign is_word_o   = (amt_o == AW'(W));
  assign over_word_o = (amt_o > AW'(W));
  assign low_o       = amt_o[LG-1:0];
endmodule

// File: rtl/shf_barrel.sv
module shf_barrel #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]         data_i,
  input  logic [$clog2(W)-1:0] amt_i,
  input  logic                 rot_i,
  input  logic                 fill_i,
  output logic [W-1:0]         data_o
);
  localparam int unsigned LG = $clog2(W);

  logic [W-1:0] stage [LG+1];
  assign stage[0] = data_i;

  for (genvar s = 0; s < LG; s++) begin : g_stage
    localparam int unsigned D = 1 << s;
    logic [D-1:0] hi_bits;
    assign hi_bits = rot_i ? stage[s][D-1:0] : {D{fill_i}};
    assign stage[s+1] = amt_i[s] ? {hi_bits, stage[s][W-1:D]} : stage[s];
  end

  assign data_o = stage[LG];
endmodule

// File: rtl/shf_flags.sv
module shf_flags #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] res_i,
  input  logic         c_val_i,
  input  logic         c_chg_i,
  input  logic         carry_i,
  input  logic         flag_en_i,
  output logic         neg_o,
  output logic         neg_upd_o,
  output logic         zero_o,
  output logic         zero_upd_o,
  output logic         carry_o,
  output logic         carry_upd_o
);
  assign neg_o       = res_i[W-1];
  assign zero_o      = (res_i == '0);
  assign neg_upd_o   = flag_en_i;
  assign zero_upd_o  = flag_en_i;
  assign carry_upd_o = flag_en_i & c_chg_i;
  assign carry_o     = carry_upd_o ? c_val_i : carry_i;
endmodule

// File: rtl/shifter_unit.sv
module shifter_unit #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]         opnd_i,
  input  logic [2:0]           op_i,
  input  logic                 amt_reg_sel_i,
  input  logic [$clog2(W):0]   amt_imm_i,
  input  logic [W-1:0]         amt_reg_i,
  input  logic                 carry_i,
  input  logic                 flag_en_i,
  output logic [W-1:0]         result_o,
  output logic                 neg_o,
  output logic                 neg_upd_o,
  output logic                 zero_o,
  output logic                 zero_upd_o,
  output logic                 carry_o,
  output logic                 carry_upd_o
);
  import shf_pkg::*;
  localparam int unsigned LG = $clog2(W);
  localparam int unsigned AW = AMT_W;

  shf_op_e         op;
  logic [AW-1:0]   amt;
  logic            amt_zero, amt_word, amt_over;
  logic [LG-1:0]   amt_low;
  logic [W-1:0]    rev_in, rev_out, brl_in, brl_out, res;
  logic            is_left, is_rot, fill;
  logic [LG-1:0]   idx_r, idx_l;
  logic            c_val, c_chg;

  assign op = shf_op_e'(op_i);

  shf_amt #(.W(W)) u_amt (
    .reg_sel_i   (amt_reg_sel_i),
    .imm_i       (amt_imm_i),
    .reg_i       (amt_reg_i),
    .amt_o       (amt),
    .is_zero_o   (amt_zero),
    .is_word_o   (amt_word),
    .over_word_o (amt_over),
    .low_o       (amt_low)
  );

  // Left shift reuses the right barrel through bit reversal.
  for (genvar b = 0; b < W; b++) begin : g_rev
    assign rev_in[b]  = opnd_i[W-1-b];
    assign rev_out[b] = brl_out[W-1-b];
  end

  assign is_left = (op == OP_LSL);
  assign is_rot  = (op == OP_ROR);
  assign fill    = (op == OP_ASR) ? opnd_i[W-1] : 1'b0;
  assign brl_in  = is_left ? rev_in : opnd_i;

  shf_barrel #(.W(W)) u_brl (
    .data_i (brl_in),
    .amt_i  (amt_low),
    .rot_i  (is_rot),
    .fill_i (fill),
    .data_o (brl_out)
  );

  assign idx_r = amt_low - LG'(1);
  assign idx_l = LG'(0) - amt_low;

  always_comb begin
    res   = opnd_i;
    c_val = 1'b0;
    c_chg = 1'b0;
    unique case (op)
      OP_ASR: begin
        if (amt_zero) begin
          res = opnd_i;
        end else if (amt_word || amt_over) begin
          res   = {W{opnd_i[W-1]}};
          c_val = opnd_i[W-1];
          c_chg = 1'b1;
        end else begin
          res   = brl_out;
          c_val = opnd_i[idx_r];
          c_chg = 1'b1;
        end
      end
      OP_LSL, OP_LSR: begin
        if (amt_zero) begin
          res = opnd_i;
        end else if (amt_word) begin
          res   = '0;
          c_val = is_left ? opnd_i[0] : opnd_i[W-1];
          c_chg = 1'b1;
        end else if (amt_over) begin
          res   = '0;
          c_val = 1'b0;
          c_chg = 1'b1;
        end else begin
          res   = is_left ? rev_out : brl_out;
          c_val = is_left ? opnd_i[idx_l] : opnd_i[idx_r];
          c_chg = 1'b1;
        end
      end
      OP_ROR: begin
        if (amt_zero) begin
          res = opnd_i;
        end else if (amt_low == '0) begin
          res   = opnd_i;
          c_val = opnd_i[W-1];
          c_chg = 1'b1;
        end else begin
          res   = brl_out;
          c_val = brl_out[W-1];
          c_chg = 1'b1;
        end
      end
      OP_RRC: begin
        res   = {carry_i, opnd_i[W-1:1]};
        c_val = opnd_i[0];
        c_chg = 1'b1;
      end
      default: begin
        res   = opnd_i;
        c_chg = 1'b0;
      end
    endcase
  end

  assign result_o = res;

  shf_flags #(.W(W)) u_flags (
    .res_i       (res),
    .c_val_i     (c_val),
    .c_chg_i     (c_chg),
    .carry_i     (carry_i),
    .flag_en_i   (flag_en_i),
    .neg_o       (neg_o),
    .neg_upd_o   (neg_upd_o),
    .zero_o      (zero_o),
    .zero_upd_o  (zero_upd_o),
    .carry_o     (carry_o),
    .carry_upd_o (carry_upd_o)
  );
endmodule

// File: rtl/shifter_unit_chk.sv
module shifter_unit_chk #(
  parameter int unsigned W = 32
) (
  input logic [W-1:0]         opnd_i,
  input logic [2:0]           op_i,
  input logic                 amt_reg_sel_i,
  input logic [$clog2(W):0]   amt_imm_i,
  input logic [W-1:0]         amt_reg_i,
  input logic                 carry_i,
  input logic                 flag_en_i,
  input logic [W-1:0]         result_o,
  input logic                 neg_o,
  input logic                 neg_upd_o,
  input logic                 zero_o,
  input logic                 zero_upd_o,
  input logic                 carry_o,
  input logic                 carry_upd_o
);
  localparam int unsigned LG = $clog2(W);
  logic [7:0] eff;
  assign eff = amt_reg_sel_i ? amt_reg_i[7:0] : {{(8-LG-1){1'b0}}, amt_imm_i};

  always_comb begin
    if (op_i == 3'd4) begin
      assert_rrc_shape_R5: assert (result_o == {carry_i, opnd_i[W-1:1]});
      if (flag_en_i) begin
        assert_rrc_carry_R5: assert (carry_upd_o && carry_o == opnd_i[0]);
      end
    end
    if (op_i < 3'd4 && eff == 8'd0) begin
      assert_zero_amt_R8: assert (result_o == opnd_i && !carry_upd_o);
    end
    if ((op_i == 3'd1 || op_i == 3'd2) && eff > 8'(W)) begin
      assert_logic_over_R9: assert (result_o == '0 && !carry_o || !carry_upd_o && result_o == '0);
    end
    if (op_i == 3'd0 && eff >= 8'(W)) begin
      assert_asr_sat_R10: assert (result_o == {W{opnd_i[W-1]}});
    end
    if (!flag_en_i) begin
      assert_no_strobe_R12: assert (!neg_upd_o && !zero_upd_o && !carry_upd_o && carry_o == carry_i);
    end
    if (!carry_upd_o) begin
      assert_carry_hold_R8: assert (carry_o == carry_i);
    end
    assert_flags_R7: assert (neg_o == result_o[W-1] && zero_o == (result_o == '0));
  end
endmodule

bind shifter_unit shifter_unit_chk #(.W(W)) u_chk (.*);

// File: tb/tb_shifter_unit.sv
module tb_shifter_unit;
  localparam int unsigned W = 32;

  logic        clk;
  logic [31:0] opnd;
  logic [2:0]  op;
  logic        sel;
  logic [5:0]  imm;
  logic [31:0] rg;
  logic        cin;
  logic        fen;
  logic [31:0] res;
  logic        n, n_upd, z, z_upd, c, c_upd;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  shifter_unit #(.W(W)) dut (
    .opnd_i(opnd), .op_i(op), .amt_reg_sel_i(sel), .amt_imm_i(imm),
    .amt_reg_i(rg), .carry_i(cin), .flag_en_i(fen),
    .result_o(res), .neg_o(n), .neg_upd_o(n_upd), .zero_o(z),
    .zero_upd_o(z_upd), .carry_o(c), .carry_upd_o(c_upd)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [2:0]  op;
    logic        sel;
    logic [5:0]  imm;
    logic [31:0] rg;
    logic [31:0] opnd;
    logic        cin;
    logic [31:0] res;
    logic        c;
    logic        cupd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, 6'd4,  32'h0,        32'h800000F1, 1'b0, 32'hF800000F, 1'b0, 1'b1, 4'd1},  // R1
    '{3'd0, 1'b0, 6'd1,  32'h0,        32'h00000001, 1'b0, 32'h00000000, 1'b1, 1'b1, 4'd7},  // R7
    '{3'd1, 1'b0, 6'd4,  32'h0,        32'h12345678, 1'b0, 32'h23456780, 1'b1, 1'b1, 4'd2},  // R2
    '{3'd1, 1'b0, 6'd31, 32'h0,        32'h00000003, 1'b0, 32'h80000000, 1'b1, 1'b1, 4'd2},  // R2
    '{3'd2, 1'b0, 6'd8,  32'h0,        32'h800000F1, 1'b0, 32'h00800000, 1'b1, 1'b1, 4'd3},  // R3
    '{3'd2, 1'b0, 6'd32, 32'h0,        32'h800000F1, 1'b0, 32'h00000000, 1'b1, 1'b1, 4'd9},  // R9
    '{3'd3, 1'b0, 6'd8,  32'h0,        32'h800000F1, 1'b0, 32'hF1800000, 1'b1, 1'b1, 4'd4},  // R4
    '{3'd4, 1'b0, 6'd7,  32'h0,        32'h800000F1, 1'b1, 32'hC0000078, 1'b1, 1'b1, 4'd5},  // R5
    '{3'd4, 1'b0, 6'd0,  32'h0,        32'h00000002, 1'b0, 32'h00000001, 1'b0, 1'b1, 4'd5},  // R5
    '{3'd2, 1'b1, 6'd0,  32'hFFFFFF04, 32'h800000F1, 1'b0, 32'h0800000F, 1'b0, 1'b1, 4'd6},  // R6
    '{3'd1, 1'b1, 6'd0,  32'h00000100, 32'h800000F1, 1'b1, 32'h800000F1, 1'b1, 1'b0, 4'd6},  // R6
    '{3'd1, 1'b0, 6'd0,  32'h0,        32'h800000F1, 1'b1, 32'h800000F1, 1'b1, 1'b0, 4'd8},  // R8
    '{3'd0, 1'b1, 6'd5,  32'h0,        32'h800000F1, 1'b0, 32'h800000F1, 1'b0, 1'b0, 4'd8},  // R8
    '{3'd1, 1'b1, 6'd0,  32'h20,       32'h800000F1, 1'b0, 32'h00000000, 1'b1, 1'b1, 4'd9},  // R9
    '{3'd2, 1'b1, 6'd0,  32'h21,       32'h800000F1, 1'b0, 32'h00000000, 1'b0, 1'b1, 4'd9},  // R9
    '{3'd1, 1'b1, 6'd0,  32'hC8,       32'h800000F1, 1'b1, 32'h00000000, 1'b0, 1'b1, 4'd9},  // R9
    '{3'd0, 1'b1, 6'd0,  32'h28,       32'h800000F1, 1'b0, 32'hFFFFFFFF, 1'b1, 1'b1, 4'd10}, // R10
    '{3'd0, 1'b0, 6'd32, 32'h0,        32'h12345678, 1'b1, 32'h00000000, 1'b0, 1'b1, 4'd10}, // R10
    '{3'd3, 1'b1, 6'd0,  32'h24,       32'h800000F1, 1'b0, 32'h1800000F, 1'b0, 1'b1, 4'd11}, // R11
    '{3'd3, 1'b1, 6'd0,  32'h40,       32'h800000F1, 1'b0, 32'h800000F1, 1'b1, 1'b1, 4'd11}, // R11
    '{3'd5, 1'b0, 6'd3,  32'h0,        32'h12345678, 1'b1, 32'h12345678, 1'b1, 1'b0, 4'd13}  // R13
  };

  task automatic apply(input logic [2:0] o, input logic s, input logic [5:0] im,
                       input logic [31:0] r, input logic [31:0] d,
                       input logic ci, input logic fe);
    @(posedge clk);
    op = o; sel = s; imm = im; rg = r; opnd = d; cin = ci; fen = fe;
    @(negedge clk);
  endtask

  task automatic check(input int req, input logic [31:0] e_res, input logic e_c,
                       input logic e_cupd, input logic e_fupd);
    logic [37:0] act, exp_v;
    act   = {res, n, n_upd, z, z_upd, c, c_upd};
    exp_v = {e_res, e_res[31], e_fupd, (e_res == 32'h0), e_fupd, e_c, e_cupd};
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL R%0d: actual res=%h n=%b/%b z=%b/%b c=%b/%b expected res=%h n=%b/%b z=%b/%b c=%b/%b",
               req, res, n, n_upd, z, z_upd, c, c_upd,
               e_res, e_res[31], e_fupd, (e_res == 32'h0), e_fupd, e_c, e_cupd);
    end
  endtask

  initial begin
    op = 3'd0; sel = 1'b0; imm = '0; rg = '0; opnd = '0; cin = 1'b0; fen = 1'b0;
    @(negedge clk);
    // Idle inputs: zero word, no strobes (R12)
    check(12, 32'h0, 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].sel, VECS[i].imm, VECS[i].rg, VECS[i].opnd, VECS[i].cin, 1'b1);
      check(int'(VECS[i].req), VECS[i].res, VECS[i].c, VECS[i].cupd, 1'b1);
    end

    // R12: flag update disabled, result still produced, carry passes through
    apply(3'd2, 1'b0, 6'd8, 32'h0, 32'h800000F1, 1'b0, 1'b0);
    check(12, 32'h00800000, 1'b0, 1'b0, 1'b0);
    apply(3'd4, 1'b0, 6'd0, 32'h0, 32'h800000F1, 1'b1, 1'b0);
    check(12, 32'hC0000078, 1'b1, 1'b0, 1'b0);
    // R3: register byte select with amount 1
    apply(3'd2, 1'b1, 6'd0, 32'h12345601, 32'h00000003, 1'b0, 1'b1);
    check(3, 32'h00000001, 1'b1, 1'b1, 1'b1);
    // R1: positive operand, shift by 31
    apply(3'd0, 1'b0, 6'd31, 32'h0, 32'h40000000, 1'b0, 1'b1);
    check(1, 32'h00000000, 1'b1, 1'b1, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule